// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Cycle Sequencer

This block is a bus master for one job only: it runs the interrupt acknowledge read cycle on an asynchronous bus with a 32-bit address and 16-bit data. Seven active-low request lines, one for each priority level from 1 to 7, pass through a synchronizer. A priority encoder then picks the highest pending level. That level is compared with the core's 3-bit mask, and the sequencer starts an acknowledge cycle at the next instruction boundary.

The acknowledge cycle marks itself as a special read in three ways. The function code is fixed at CPU space. The address type nibble is all ones, and every other address bit is one except the three that carry the level. A per-level strobe also tells the requesting device that its level is being served. The responder ends the cycle in one of two ways. It can return a vector byte with a port-size acknowledge, or it can ask for an autovector. The sequencer stores the vector, releases the strobes and waits for the responder to drop its handshake. It then gives the core a one-cycle completion pulse carrying the vector and the level.

Top module: `iack_sequencer`

## Requirements
- R1: After reset the address strobe, data strobe and all seven level strobes are high (negated), `ackDone` is low, the function code is 0 and `busRnW` is 1.
- R2: While `asN` is low, `busFc` is 4'b0111, `busRnW` is 1 (read) and `busSize` is 2'b01 (one byte).
- R3: While `asN` is low, `busAddr[3:1]` holds the acknowledged level and every other bit of `busAddr` is 1. This means bits 19..16 read 4'hF.
- R4: While `asN` is low, exactly one bit of `iackN` is low, and it is bit `iackN[L]` for acknowledged level L. While `asN` is high, all bits of `iackN` are high.
- R5: When several request lines are low, the highest-numbered level is acknowledged first.
- R6: A request of level L is accepted only if L > `maskLevel`. Level 7 is always accepted, whatever the mask. A request that is masked starts no cycle.
- R7: A cycle starts only while `instrDone` is high. While it is low, pending requests start no cycle.
- R8: A termination with `dsackN` = 2'b01 (8-bit port) takes the vector from `dataIn[15:8]`.
- R9: A termination with `dsackN` = 2'b10 (16-bit port) takes the vector from `dataIn[7:0]`.
- R10: A termination with `avecN` low returns vector 24 + L and ignores `dataIn`. This holds even if `dsackN` is also asserted.
- R11: `ackDone` is a one-cycle pulse, one per acknowledge cycle. It carries the stored vector on `ackVector` and the level on `ackLevel`.
- R12: The clock edge after termination, `asN` and `dsN` go high. No new cycle starts until both `dsackN` and `avecN` have returned high.
- R13: Address and function code are driven for one cycle before `asN` falls, and they do not change on the cycle it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqN | input | 7 | Active-low interrupt requests, bit i = level i (bits 7..1) |
| maskLevel | input | 3 | Current interrupt mask level |
| instrDone | input | 1 | High at an instruction boundary |
| dsackN | input | 2 | Active-low port-size acknowledge: 01 = 8-bit, 10 = 16-bit |
| avecN | input | 1 | Active-low autovector request |
| dataIn | input | 16 | Data bus in |
| busAddr | output | 32 | Address bus |
| busFc | output | 4 | Function code |
| busRnW | output | 1 | 1 = read |
| busSize | output | 2 | Transfer size code, 01 = one byte |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| iackN | output | 7 | Per-level acknowledge strobes, active low (bits 7..1) |
| ackDone | output | 1 | One-cycle completion pulse |
| ackVector | output | 8 | Stored vector number |
| ackLevel | output | 3 | Level that was acknowledged |

## Verification
Two functions can land on the same edge. In one case the bus is released while a second request is still pending. In the other, an autovector request and a port-size acknowledge arrive together. The first case is provoked by keeping a lower level pending and holding the responder's acknowledge after termination. The bench checks that the strobes stay high until the handshake drops, and that only then does the next level get its own cycle. The second case is provoked by asserting both terminations together with a data pattern that differs from 24 + L. The scoreboard expects the autovector value.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 16;
  localparam int FC_W       = 4;
  localparam int LVL_W      = 3;
  localparam int NUM_LEVELS = 7;
  localparam int VEC_W      = 8;
  localparam int AUTO_BASE  = 24;

  localparam logic [FC_W-1:0] FC_CPU_SPACE = 4'b0111;
  localparam logic [3:0]      TYPE_IACK    = 4'hF;
  localparam logic [1:0]      SIZE_BYTE    = 2'b01;
  localparam logic [1:0]      DSACK_BYTE   = 2'b01;
  localparam logic [1:0]      DSACK_NONE   = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_REL
  } seqState_t;

  typedef struct packed {
    logic capLevel;
    logic driveBus;
    logic strobeOn;
    logic latchVec;
    logic useAuto;
  } ctrlStrobes_t;
endpackage

// File: rtl/iack_irq_sync.sv
module iack_irq_sync
  import iack_pkg::*;
#(
  parameter int LEVELS = NUM_LEVELS,
  parameter int STAGES = 2,
  parameter int LW     = LVL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEVELS:1]   irqN,
  input  logic [LW-1:0]     maskLevel,
  output logic              pendValid,
  output logic [LW-1:0]     pendLevel
);
  localparam int LAST = STAGES - 1;

  logic [LEVELS:1] syncStage [STAGES];
  logic [LEVELS:1] reqLive;
  logic [LW-1:0]   topLevel;
  logic            anyReq;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncStage[0] <= '1;
          else       syncStage[0] <= irqN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncStage[s] <= '1;
          else       syncStage[s] <= syncStage[s-1];
        end
      end
    end
  endgenerate

  assign reqLive = ~syncStage[LAST];

  always_comb begin
    topLevel = '0;
    anyReq   = 1'b0;
    for (int i = 1; i <= LEVELS; i++) begin
      if (reqLive[i]) begin
        topLevel = LW'(i);
        anyReq   = 1'b1;
      end
    end
  end

  assign pendLevel = topLevel;
  assign pendValid = anyReq &&
                     ((topLevel > maskLevel) || (topLevel == LW'(LEVELS)));
endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
  import iack_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pendValid,
  input  logic         instrDone,
  input  logic [1:0]   dsackN,
  input  logic         avecN,
  output ctrlStrobes_t ctl
);
  seqState_t stateQ, stateD;
  logic      termAuto, termPort, respIdle;

  assign termAuto = !avecN;
  assign termPort = (dsackN != DSACK_NONE);
  assign respIdle = avecN && (dsackN == DSACK_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (pendValid && instrDone) begin
          ctl.capLevel = 1'b1;
          stateD       = ST_ADDR;
        end
      end
      ST_ADDR: begin
        ctl.driveBus = 1'b1;
        stateD       = ST_STRB;
      end
      ST_STRB: begin
        ctl.driveBus = 1'b1;
        ctl.strobeOn = 1'b1;
        if (termAuto) begin
          ctl.latchVec = 1'b1;
          ctl.useAuto  = 1'b1;
          stateD       = ST_REL;
        end else if (termPort) begin
          ctl.latchVec = 1'b1;
          stateD       = ST_REL;
        end
      end
      ST_REL: begin
        ctl.driveBus = 1'b1;
        if (respIdle) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/iack_dpath.sv
module iack_dpath
  import iack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic [LVL_W-1:0]  pendLevel,
  input  logic [1:0]        dsackN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [FC_W-1:0]   busFc,
  output logic              busRnW,
  output logic [1:0]        busSize,
  output logic              asN,
  output logic              dsN,
  output logic [NUM_LEVELS:1] iackN,
  output logic              ackDone,
  output logic [VEC_W-1:0]  ackVector,
  output logic [LVL_W-1:0]  ackLevel
);
  logic [LVL_W-1:0]  levelQ;
  logic [VEC_W-1:0]  vectorQ;
  logic              doneQ;
  logic [VEC_W-1:0]  laneByte;
  logic [VEC_W-1:0]  autoVec;
  logic [ADDR_W-1:0] iackAddr;

  assign laneByte = (dsackN == DSACK_BYTE) ? dataIn[DATA_W-1 -: VEC_W]
                                           : dataIn[VEC_W-1:0];
  assign autoVec  = VEC_W'(AUTO_BASE) + VEC_W'(levelQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ  <= '0;
      vectorQ <= '0;
      doneQ   <= 1'b0;
    end else begin
      if (ctl.capLevel) levelQ <= pendLevel;
      if (ctl.latchVec) vectorQ <= ctl.useAuto ? autoVec : laneByte;
      doneQ <= ctl.latchVec;
    end
  end

  always_comb begin
    iackAddr        = '1;
    iackAddr[19:16] = TYPE_IACK;
    iackAddr[3:1]   = levelQ;
  end

  assign busAddr = ctl.driveBus ? iackAddr : '0;
  assign busFc   = ctl.driveBus ? FC_CPU_SPACE : '0;
  assign busSize = ctl.driveBus ? SIZE_BYTE : 2'b00;
  assign busRnW  = 1'b1;
  assign asN     = !ctl.strobeOn;
  assign dsN     = !ctl.strobeOn;

  genvar g;
  generate
    for (g = 1; g <= NUM_LEVELS; g++) begin : g_iack
      assign iackN[g] = !(ctl.strobeOn && (levelQ == LVL_W'(g)));
    end
  endgenerate

  assign ackDone   = doneQ;
  assign ackVector = vectorQ;
  assign ackLevel  = levelQ;
endmodule

// File: rtl/iack_sequencer.sv
module iack_sequencer
  import iack_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LEVELS:1]  irqN,
  input  logic [LVL_W-1:0]     maskLevel,
  input  logic                 instrDone,
  input  logic [1:0]           dsackN,
  input  logic                 avecN,
  input  logic [DATA_W-1:0]    dataIn,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [FC_W-1:0]      busFc,
  output logic                 busRnW,
  output logic [1:0]           busSize,
  output logic                 asN,
  output logic                 dsN,
  output logic [NUM_LEVELS:1]  iackN,
  output logic                 ackDone,
  output logic [VEC_W-1:0]     ackVector,
  output logic [LVL_W-1:0]     ackLevel
);
  ctrlStrobes_t     ctl;
  logic             pendValid;
  logic [LVL_W-1:0] pendLevel;

  iack_irq_sync #(.LEVELS(NUM_LEVELS), .STAGES(2), .LW(LVL_W)) sync_i (
    .clk(clk), .rstN(rstN), .irqN(irqN), .maskLevel(maskLevel),
    .pendValid(pendValid), .pendLevel(pendLevel)
  );

  iack_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pendValid(pendValid), .instrDone(instrDone),
    .dsackN(dsackN), .avecN(avecN), .ctl(ctl)
  );

  iack_dpath dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pendLevel(pendLevel),
    .dsackN(dsackN), .dataIn(dataIn),
    .busAddr(busAddr), .busFc(busFc), .busRnW(busRnW), .busSize(busSize),
    .asN(asN), .dsN(dsN), .iackN(iackN),
    .ackDone(ackDone), .ackVector(ackVector), .ackLevel(ackLevel)
  );
endmodule

// File: rtl/iack_sequencer_chk.sv
module iack_sequencer_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:1]  iackN,
  input logic [31:0] busAddr,
  input logic [3:0]  busFc,
  input logic        busRnW,
  input logic [1:0]  busSize,
  input logic        asN,
  input logic        dsN,
  input logic        ackDone
);
  a_r2_fc_read_byte: assert property (@(posedge clk) disable iff (!rstN)
    !asN |-> (busFc == 4'b0111 && busRnW && busSize == 2'b01));

  a_r3_addr_ones: assert property (@(posedge clk) disable iff (!rstN)
    !asN |-> (busAddr[31:4] == 28'hFFFFFFF && busAddr[0]));

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !asN |-> ((~iackN) == (7'b1 << (busAddr[3:1] - 3'd1))));

  a_r4_no_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    asN |-> (iackN == 7'h7F));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ackDone |=> !ackDone);

  a_r12_released: assert property (@(posedge clk) disable iff (!rstN)
    ackDone |-> (asN && dsN));

  a_r13_addr_setup: assert property (@(posedge clk) disable iff (!rstN)
    $fell(asN) |-> ($stable(busAddr) && $stable(busFc)));
endmodule

bind iack_sequencer iack_sequencer_chk chk_i (
  .clk(clk), .rstN(rstN), .iackN(iackN), .busAddr(busAddr), .busFc(busFc),
  .busRnW(busRnW), .busSize(busSize), .asN(asN), .dsN(dsN), .ackDone(ackDone)
);

// File: tb/iack_sequencer_tb.sv
module iack_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:1]  irqN = 7'h7F;
  logic [2:0]  maskLevel = 3'd0;
  logic        instrDone = 1'b1;
  logic [1:0]  dsackN = 2'b11;
  logic        avecN = 1'b1;
  logic [15:0] dataIn = 16'h0;
  logic [31:0] busAddr;
  logic [3:0]  busFc;
  logic        busRnW;
  logic [1:0]  busSize;
  logic        asN, dsN;
  logic [7:1]  iackN;
  logic        ackDone;
  logic [7:0]  ackVector;
  logic [2:0]  ackLevel;

  int checks = 0;
  int errors = 0;
  logic [10:0] expQ[$];
  logic prevDone = 1'b0;

  always #10 clk = ~clk;

  iack_sequencer dut_i (
    .clk(clk), .rstN(rstN), .irqN(irqN), .maskLevel(maskLevel),
    .instrDone(instrDone), .dsackN(dsackN), .avecN(avecN), .dataIn(dataIn),
    .busAddr(busAddr), .busFc(busFc), .busRnW(busRnW), .busSize(busSize),
    .asN(asN), .dsN(dsN), .iackN(iackN), .ackDone(ackDone),
    .ackVector(ackVector), .ackLevel(ackLevel)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each completion pulse (R11, and R8/R9/R10 values)
  always @(negedge clk) begin
    if (rstN) begin
      if (ackDone) begin
        if (prevDone) check(1'b0, "R11 pulse width", 32'd2, 32'd1);
        if (expQ.size() == 0) check(1'b0, "R11 unexpected done", 32'd1, 32'd0);
        else begin
          logic [10:0] e;
          e = expQ.pop_front();
          check({ackLevel, ackVector} == e, "R11 R8 R9 R10 level/vector",
                {21'd0, ackLevel, ackVector}, {21'd0, e});
        end
      end
      prevDone = ackDone;
    end
  end

  // Driver: wait for the strobe, check the bus, respond, push expected item
  task automatic doAck(input int lvl, input logic [1:0] ds, input logic av,
                       input logic [15:0] d, input logic [7:0] expVec,
                       input string tag);
    int waitN = 0;
    logic [31:0] expAddr;
    while (asN && waitN < 40) begin
      @(negedge clk);
      waitN++;
    end
    check(!asN, {tag, " R5 R6 R7 cycle started"}, {31'd0, asN}, 32'd0);
    if (asN) return;
    expAddr = 32'hFFFF_FFF1 | (32'(lvl) << 1);
    check(busFc == 4'b0111 && busRnW && busSize == 2'b01, {tag, " R2 fc/rw/size"},
          {25'd0, busFc, busRnW, busSize}, {25'd0, 4'b0111, 1'b1, 2'b01});
    check(busAddr == expAddr, {tag, " R3 address"}, busAddr, expAddr);
    check(iackN == ~(7'b1 << (lvl - 1)), {tag, " R4 level strobe"},
          {25'd0, iackN}, {25'd0, ~(7'b1 << (lvl - 1))});
    expQ.push_back({3'(lvl), expVec});
    dsackN = ds;
    avecN  = av;
    dataIn = d;
    irqN[lvl] = 1'b1;
    // hold the handshake: strobes must release and no new cycle may start (R12)
    repeat (4) begin
      @(negedge clk);
      check(asN && dsN, {tag, " R12 held release"}, {30'd0, asN, dsN}, 32'd3);
    end
    dsackN = 2'b11;
    avecN  = 1'b1;
    dataIn = 16'h0;
    @(negedge clk);
  endtask

  task automatic expectIdle(input int n, input string tag);
    bit quiet = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (!asN || iackN != 7'h7F) quiet = 1'b0;
    end
    check(quiet, tag, {31'd0, !quiet}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(asN && dsN && iackN == 7'h7F && !ackDone && busFc == 4'h0 && busRnW,
          "R1 reset outputs", {22'd0, asN, dsN, iackN, ackDone}, {22'd0, 2'b11, 7'h7F, 1'b0});
    rstN = 1'b1;
    @(negedge clk);

    // R9 16-bit port, level 5 above mask 2
    maskLevel = 3'd2; irqN[5] = 1'b0;
    doAck(5, 2'b10, 1'b1, 16'h1234, 8'h34, "t1");
    // R8 8-bit port, level 3
    maskLevel = 3'd0; irqN[3] = 1'b0;
    doAck(3, 2'b01, 1'b1, 16'hAB12, 8'hAB, "t2");
    // R10 autovector, level 4, data ignored
    irqN[4] = 1'b0;
    doAck(4, 2'b11, 1'b0, 16'h5555, 8'd28, "t3");
    // R10 autovector wins over a simultaneous size acknowledge
    irqN[1] = 1'b0;
    doAck(1, 2'b10, 1'b0, 16'h00EE, 8'd25, "t4");
    // R5 priority: 2 and 6 pending, 6 first, then 2 after release (R12)
    irqN[2] = 1'b0; irqN[6] = 1'b0;
    doAck(6, 2'b10, 1'b1, 16'h0040, 8'h40, "t5a R5");
    doAck(2, 2'b01, 1'b1, 16'h4100, 8'h41, "t5b R5");
    // R6 masked request ignored
    maskLevel = 3'd3; irqN[3] = 1'b0;
    expectIdle(10, "R6 masked level 3 at mask 3");
    irqN[3] = 1'b1;
    expectIdle(4, "R6 settle");
    // R6 level 7 accepted even at mask 7
    maskLevel = 3'd7; irqN[7] = 1'b0;
    doAck(7, 2'b10, 1'b1, 16'h00C7, 8'hC7, "t6 R6 level7");
    // R7 no cycle without instruction boundary
    maskLevel = 3'd0; instrDone = 1'b0; irqN[5] = 1'b0;
    expectIdle(10, "R7 waits for instrDone");
    instrDone = 1'b1;
    doAck(5, 2'b01, 1'b1, 16'h9900, 8'h99, "t7 R7");
    expectIdle(6, "R7 R12 idle after last");
    check(expQ.size() == 0, "R11 all completions seen", expQ.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule